// File: doc/BRIEF.md
# Request-Driven Clock Mode Controller

This block supervises the clocking of a locally synchronous pipeline. As long as request transitions keep arriving on the input channel, the pipeline advances only once per accepted request, so data movement makes no additional clock edges. When the input channel goes quiet, the block counts falling edges of a free-running local clock source. Once enough edges have passed, it releases a burst of local clock pulses sized to the pipeline depth, so data still held in the stages is flushed out. After that it stalls until the next request.

The model is fully synchronous to a system clock. The request line uses two-phase signalling: a request is pending whenever `req_i` differs from `ack_o`. The local clock source arrives as a sampled level on `lclk_i`. A local cycle opens at a sampled rising level and closes at the next sampled low level. If a request arrives while a local cycle is open, the block finishes that cycle before it gives the clock back to the request line.

Top module: `req_clk_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, mode_o is 00 (idle), pulse_o is 0 and ack_o is 0. Both counters start at zero.
- R2: In idle (00) or request-driven (01) mode, a pending request (req_i != ack_o) produces one pulse_o cycle on the next cycle. In that same cycle ack_o toggles and mode_o becomes 01. While in mode 01, the local clock makes no pulses.
- R3: In mode 01, each sampled falling edge of lclk_i (previous sample 1, current sample 0) advances the idle counter. Accepting a request clears that counter, so a time-out needs IDLE_FALLS consecutive falls with no handshake in between.
- R4: When the IDLE_FALLS-th fall is sampled with no request pending, mode_o becomes 10 (local flush) on the next cycle, without a pulse.
- R5: In mode 10, each sampled rising edge of lclk_i (previous 0, current 1) with no request pending produces one pulse_o on the next cycle. The PIPE_DEPTH-th such pulse appears together with mode_o returning to 00.
- R6: In idle mode, lclk_i activity has no effect: mode_o stays 00 and pulse_o stays 0.
- R7: A request that arrives in mode 10 while lclk_i is sampled high both now and on the previous cycle moves mode_o to 11 (handover). In mode 11, ack_o holds and no pulses are issued. At the first sample with lclk_i low, the request is served as in R2.
- R8: A request that arrives in mode 10 with no local cycle open is served at once, as in R2. A rising edge sampled in that same cycle adds no second pulse.
- R9: Serving a request clears the flush counter. A later time-out therefore issues a full burst of PIPE_DEPTH pulses, even if an earlier flush was cut short by a handover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Two-phase request from the upstream stage |
| lclk_i | input | 1 | Sampled level of the local clock source |
| ack_o | output | 1 | Two-phase acknowledge; toggles when a request is served |
| pulse_o | output | 1 | One-cycle clock pulse to the pipeline |
| mode_o | output | 2 | Clock mode: 00 idle, 01 request-driven, 10 local flush, 11 handover |

## Verification
The stimulus alternates between three kinds of traffic. Dense request bursts check that a busy channel never times out. Long silences check the exact time-out point and the size of the flush burst. Sparse requests spaced just under the time-out check that each handshake clears the idle count. Directed cases place a request at chosen points in a flush: while the local level is held high, which must lead to handover and a delayed serve, and on a rising sample, which must give an immediate serve with a single pulse. A handover-interrupted flush is followed by a fresh silence, to show that the next burst is full length rather than the remainder.

// File: rtl/req_clk_pkg.sv
package req_clk_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_REQ   = 2'b01,
    MODE_FLUSH = 2'b10,
    MODE_HAND  = 2'b11
  } mode_e;
endpackage

// File: rtl/lclk_edge.sv
module lclk_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lclk_i,
  output logic lvl_q_o,
  output logic rise_o,
  output logic fall_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q_o <= 1'b0;
    else         lvl_q_o <= lclk_i;
  end

  assign rise_o = !lvl_q_o && lclk_i;
  assign fall_o = lvl_q_o && !lclk_i;
endmodule

// File: rtl/wrap_cnt.sv
module wrap_cnt #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic hit_o
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign hit_o = inc_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= hit_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/req_clk_ctrl.sv
module req_clk_ctrl
  import req_clk_pkg::*;
#(
  parameter int unsigned PIPE_DEPTH = 4,
  parameter int unsigned IDLE_FALLS = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       lclk_i,
  output logic       ack_o,
  output logic       pulse_o,
  output logic [1:0] mode_o
);
  mode_e mode_q, mode_d;
  logic  ack_q, pulse_q;
  logic  lvl_q, rise, fall;
  logic  pend, busy, serve;
  logic  tout_inc, tout_clr, tout_hit;
  logic  fl_inc, fl_clr, flush_hit;

  lclk_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lclk_i (lclk_i),
    .lvl_q_o(lvl_q),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign pend = req_i ^ ack_q;
  assign busy = lvl_q && lclk_i;  // local cycle still open

  always_comb begin
    unique case (mode_q)
      MODE_IDLE, MODE_REQ: serve = pend;
      MODE_FLUSH:          serve = pend && !busy;
      MODE_HAND:           serve = pend && !lclk_i;
      default:             serve = 1'b0;
    endcase
  end

  assign tout_inc = (mode_q == MODE_REQ) && fall && !pend;
  assign tout_clr = serve || (mode_q != MODE_REQ);
  assign fl_inc   = (mode_q == MODE_FLUSH) && rise && !pend;
  assign fl_clr   = serve || (mode_q == MODE_IDLE);

  wrap_cnt #(.LIMIT(IDLE_FALLS)) u_tout (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tout_clr),
    .inc_i (tout_inc),
    .hit_o (tout_hit)
  );

  wrap_cnt #(.LIMIT(PIPE_DEPTH)) u_flush (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (fl_clr),
    .inc_i (fl_inc),
    .hit_o (flush_hit)
  );

  always_comb begin
    mode_d = mode_q;
    if (serve)                                    mode_d = MODE_REQ;
    else if (mode_q == MODE_REQ && tout_hit)      mode_d = MODE_FLUSH;
    else if (mode_q == MODE_FLUSH && pend)        mode_d = MODE_HAND;
    else if (mode_q == MODE_FLUSH && flush_hit)   mode_d = MODE_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_IDLE;
      ack_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      ack_q   <= ack_q ^ serve;
      pulse_q <= serve || fl_inc;
    end
  end

  assign ack_o   = ack_q;
  assign pulse_o = pulse_q;
  assign mode_o  = mode_q;
endmodule

// File: rtl/req_clk_ctrl_chk.sv
module req_clk_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       ack_o,
  input logic       pulse_o,
  input logic [1:0] mode_o,
  input logic       tout_hit
);
  a_r2_ack_brings_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o != $past(ack_o)) |-> (pulse_o && mode_o == 2'b01));

  a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b00 && req_i == ack_o) |=> (!pulse_o && mode_o == 2'b00));

  a_r7_handover_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b11) |-> (!pulse_o && $stable(ack_o)));

  a_r4_flush_after_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b10 && $past(mode_o) == 2'b01) |-> ($past(tout_hit) && !pulse_o));

  a_r5_flush_end_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b00 && $past(mode_o) == 2'b10) |-> pulse_o);
endmodule

bind req_clk_ctrl req_clk_ctrl_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .ack_o   (ack_o),
  .pulse_o (pulse_o),
  .mode_o  (mode_o),
  .tout_hit(tout_hit)
);

// File: tb/req_clk_ctrl_bench.sv
`timescale 1ns/1ps
module req_clk_ctrl_bench;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned FALLS = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_r = 1'b0;
  logic       lclk_r = 1'b0;
  logic       ack_w, pulse_w;
  logic [1:0] mode_w;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  string tag = "R1";

  // reference model state
  logic [1:0] m_mode = 2'b00;
  logic       m_ack = 1'b0, m_pulse = 1'b0, m_lq = 1'b0;
  int         m_tc = 0, m_fc = 0;
  int         hcnt = 0, half = 2;

  req_clk_ctrl #(.PIPE_DEPTH(DEPTH), .IDLE_FALLS(FALLS)) u_req_clk_ctrl (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .req_i  (req_r),
    .lclk_i (lclk_r),
    .ack_o  (ack_w),
    .pulse_o(pulse_w),
    .mode_o (mode_w)
  );

  always #4 clk = ~clk;

  task automatic check(input string t, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d @%0t", t, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    check(tag, "pulse", pulse_w, m_pulse);
    check(tag, "ack", ack_w, m_ack);
    check(tag, "mode", mode_w, m_mode);
    if (pulse_w) pulses++;
  endtask

  // expected behaviour from the requirements
  task automatic model_step(input logic r, input logic l);
    logic pend, rise, fall, busy, serve, finc;
    pend = r != m_ack;
    rise = !m_lq && l;
    fall = m_lq && !l;
    busy = m_lq && l;
    case (m_mode)
      2'b00, 2'b01: serve = pend;
      2'b10:        serve = pend && !busy;
      default:      serve = pend && !l;
    endcase
    finc = (m_mode == 2'b10) && rise && !pend;
    m_pulse = serve || finc;
    if (serve) begin
      m_ack = ~m_ack; m_mode = 2'b01; m_tc = 0; m_fc = 0;
    end else if (m_mode == 2'b01) begin
      if (fall) begin
        m_tc++;
        if (m_tc == FALLS) begin m_tc = 0; m_mode = 2'b10; end
      end
    end else if (m_mode == 2'b10) begin
      if (pend) m_mode = 2'b11;
      else if (finc) begin
        m_fc++;
        if (m_fc == DEPTH) begin m_fc = 0; m_mode = 2'b00; end
      end
    end
    if (m_mode == 2'b00) m_fc = 0;
    m_lq = l;
  endtask

  task automatic cyc(input logic r, input logic l);
    req_r = r;
    lclk_r = l;
    model_step(r, l);
    @(negedge clk);
    compare();
  endtask

  // free-running local clock, request toggled with chance 1/prob (0 = never)
  task automatic osc(input int n, input int prob);
    for (int i = 0; i < n; i++) begin
      logic r, l;
      r = req_r;
      l = lclk_r;
      hcnt++;
      if (hcnt >= half) begin
        hcnt = 0;
        l = ~l;
        half = 1 + $urandom_range(2);
      end
      if (prob != 0 && r == m_ack && $urandom_range(prob - 1) == 0) r = ~r;
      cyc(r, l);
    end
  endtask

  task automatic wait_mode(input logic [1:0] md);
    for (int i = 0; i < 400 && m_mode != md; i++) osc(1, 0);
  endtask

  initial begin
    int p0;
    void'($urandom(32'd1234));
    #1;
    check("R1", "mode in reset", mode_w, 0);
    check("R1", "pulse in reset", pulse_w, 0);
    check("R1", "ack in reset", ack_w, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare();

    tag = "R6";
    p0 = pulses;
    osc(40, 0);
    check("R6", "idle pulses", pulses - p0, 0);
    check("R6", "idle mode", mode_w, 0);

    tag = "R2";
    cyc(~req_r, lclk_r);
    check("R2", "serve pulse", pulse_w, 1);
    check("R2", "serve mode", mode_w, 1);
    osc(60, 2);

    tag = "R3";
    osc(300, 18);

    tag = "R4";
    wait_mode(2'b10);
    check("R4", "timeout mode", mode_w, 2);

    tag = "R5";
    p0 = pulses;
    osc(200, 0);
    check("R5", "flush pulses", pulses - p0, DEPTH);
    check("R5", "flush end mode", mode_w, 0);

    // handover while the local cycle is open
    tag = "R7";
    cyc(~req_r, lclk_r);
    wait_mode(2'b10);
    cyc(req_r, 1'b0);
    cyc(req_r, 1'b1);
    cyc(~req_r, 1'b1);
    check("R7", "handover mode", mode_w, 3);
    cyc(req_r, 1'b1);
    check("R7", "held ack", ack_w != req_r, 1);
    check("R7", "no pulse in handover", pulse_w, 0);
    cyc(req_r, 1'b0);
    check("R7", "served mode", mode_w, 1);
    check("R7", "served pulse", pulse_w, 1);

    tag = "R9";
    wait_mode(2'b10);
    p0 = pulses;
    osc(200, 0);
    check("R9", "full burst after handover", pulses - p0, DEPTH);

    // request on a rising sample with no cycle open
    tag = "R8";
    cyc(~req_r, lclk_r);
    wait_mode(2'b10);
    cyc(req_r, 1'b0);
    cyc(req_r, 1'b0);
    p0 = pulses;
    cyc(~req_r, 1'b1);
    check("R8", "immediate mode", mode_w, 1);
    check("R8", "single pulse", pulses - p0, 1);
    check("R8", "ack caught up", ack_w == req_r, 1);

    // random mix of bursts, silences and sparse requests
    for (int s = 0; s < 60; s++) begin
      case ($urandom_range(2))
        0: begin tag = "R2"; osc(30, 2);   end
        1: begin tag = "R5"; osc(120, 0);  end
        default: begin tag = "R3"; osc(80, 15); end
      endcase
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule